// File: doc/BRIEF.md
# SDRAM Command Sequencer with Periodic Refresh

This block turns single-word read and write requests into the command stream for a four-bank single-data-rate SDRAM. It has 12 row bits and 9 column bits. After reset it runs the power-up sequence: a stable-supply wait, a precharge of every bank, two auto-refreshes and a mode register load. It then enters its idle state. Each request opens a row, issues one read or write and closes the row. The row is closed either by the auto-precharge flag carried on address bit 10 or by a precharge of that one bank. A refresh timer raises a pending flag at a fixed interval. That flag is served at the next idle cycle, ahead of any waiting request. Every minimum spacing between commands is a parameter counted in clocks; the defaults suit a 100 MHz clock. Data and burst counting are handled by neighbouring blocks.

The controller is a single state machine with ten states. STARTUP holds for the stable time. INIT_PRE issues the all-bank precharge. INIT_REF is entered twice, the second pass being selected by a flag. INIT_MRS loads the mode word. IDLE routes to REF when a refresh is pending and to ACT when a request is accepted. ACT moves to RW. RW moves to PRE, or straight to IDLE when auto-precharge is used. PRE and REF both return to IDLE. After any command whose spacing is longer than one clock, the machine passes through WAIT. A shared down-counter holds it there, and it then resumes at the state it recorded.

Top module: `sdram_sequencer`

## Requirements
- R1: The command is the 4-bit vector {cs_n, ras_n, cas_n, we_n}. Mode load is 0000, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001 and no-op 0111. No other value ever appears.
- R2: While reset is held, the output is no-op with req_ready and init_done low. After release, only no-ops are issued for at least T_INIT clocks.
- R3: The start-up commands come in this order: precharge with address bit 10 high, refresh, refresh, then mode load carrying MODE_WORD (default 0x020) on the address lines. init_done is low during the mode load, rises before the first activate and then stays high.
- R4: An accepted request produces an activate with the request's bank on sd_ba and its row on sd_addr. This is followed by a read (write when req_write is 1) with the same bank and with sd_addr = {0, auto, 0, column[8:0]}, that is bit 11 = 0, bit 10 = auto-precharge, bit 9 = 0.
- R5: When req_auto_pc is 1, address bit 10 of the read or write is 1 and no precharge command is issued for that access.
- R6: When req_auto_pc is 0, the access is closed by a precharge to the same bank with address bit 10 low, before the next activate.
- R7: Activate to read/write is at least T_RCD (2) clocks. Activate to precharge is at least T_RAS (5). Write to precharge is at least T_WR (2).
- R8: Precharge to activate is at least T_RP (2) clocks. Activate to activate is at least T_RC (7).
- R9: Refresh to the next command is at least T_RFC (7) clocks. Mode load to the next command is at least T_MRD (2).
- R10: After start-up, successive refreshes are issued between REFI-20 and REFI+20 clocks apart. A refresh that falls due is served before any request, and in a cycle that carries a refresh the request is not accepted.
- R11: Every cycle in which no command is due carries a no-op; in particular, every cycle with req_ready high carries a no-op.
- R12: req_ready is high only in the idle state with no refresh pending. A request is taken when req_valid and req_ready are both high at a clock edge, and its activate appears in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_auto_pc | input | 1 | Close the row with auto-precharge |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 12 | Row of the request |
| req_col | input | 9 | Column of the request |
| req_ready | output | 1 | Request is taken this cycle if valid |
| init_done | output | 1 | Start-up sequence finished |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Multiplexed row / column / flag address |

## Verification
A falling-due refresh and a newly presented request can meet in the same idle cycle. The bench forces this by shortening the refresh interval and holding req_valid high without a gap across several refresh periods. Each refresh issued while req_valid is high is counted as a collision, and at least one must occur. In that cycle the request must not be accepted. The activate that follows must still respect the refresh cycle time, and the bench judges the outcome from the command stream and the ready line alone.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } cmd_t;

    typedef enum logic [3:0] {
        ST_STARTUP,
        ST_INIT_PRE,
        ST_INIT_REF,
        ST_INIT_MRS,
        ST_IDLE,
        ST_ACT,
        ST_RW,
        ST_PRE,
        ST_REF,
        ST_WAIT
    } state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdseq_gap_timer.sv
module sdseq_gap_timer #(
    parameter int CW        = 8,
    parameter int INIT_LOAD = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] remaining
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= CW'(INIT_LOAD);
        end else if (load) begin
            remaining <= load_val;
        end else if (remaining != '0) begin
            remaining <= remaining - CW'(1);
        end
    end

endmodule

// File: rtl/sdseq_refresh_timer.sv
module sdseq_refresh_timer #(
    parameter int REFI = 1550
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ack,
    output logic pending
);

    localparam int RW = $clog2(REFI + 1);

    logic [RW-1:0] count;
    logic          expire;

    assign expire = enable && (count == RW'(REFI - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (expire) begin
            count <= '0;
        end else if (enable) begin
            count <= count + RW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (expire) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/sdram_sequencer.sv
module sdram_sequencer
    import sdseq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] MODE_WORD = 'h020,
    parameter int T_INIT = 20000,
    parameter int T_RCD  = 2,
    parameter int T_RP   = 2,
    parameter int T_RAS  = 5,
    parameter int T_RC   = 7,
    parameter int T_WR   = 2,
    parameter int T_RFC  = 7,
    parameter int T_MRD  = 2,
    parameter int REFI   = 1550
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_auto_pc,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_ready,
    output logic              init_done,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr
);

    localparam int AP_BIT    = 10;
    localparam int CW        = $clog2(max2(T_INIT, 64) + 1);
    localparam int G_RD_PRE  = max2(T_RAS - T_RCD, 1);
    localparam int G_WR_PRE  = max2(T_RAS - T_RCD, T_WR);
    localparam int G_RD_POST = max2(T_RP, T_RC - T_RCD - G_RD_PRE);
    localparam int G_WR_POST = max2(T_RP, T_RC - T_RCD - G_WR_PRE);
    localparam int G_RD_AP   = max2(T_RC - T_RCD, 1 + T_RP);
    localparam int G_WR_AP   = max2(T_RC - T_RCD, T_WR + T_RP);
    localparam int SAT       = max2(T_RC, max2(T_RAS, T_RP)) + 1;
    localparam int SW        = $clog2(SAT + 1);

    state_t            state, state_nxt, resume_q, resume_nxt;
    cmd_t              cmd;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_q, ap_q, second_ref_q, init_done_q;
    logic              accept, ref_pending, ref_ack;
    logic              t_load, issue;
    logic [CW-1:0]     t_val, t_rem, gap;
    state_t            after;

    sdseq_gap_timer #(.CW(CW), .INIT_LOAD(T_INIT)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .remaining(t_rem)
    );

    sdseq_refresh_timer #(.REFI(REFI)) u_refresh (
        .clk(clk), .rst_n(rst_n), .enable(init_done_q), .ack(ref_ack), .pending(ref_pending)
    );

    assign req_ready = (state == ST_IDLE) && !ref_pending;
    assign accept    = req_valid && req_ready;
    assign init_done = init_done_q;

    // next-state logic
    always_comb begin
        state_nxt  = state;
        resume_nxt = resume_q;
        t_load     = 1'b0;
        t_val      = '0;
        ref_ack    = 1'b0;
        issue      = 1'b0;
        gap        = CW'(1);
        after      = ST_IDLE;
        unique case (state)
            ST_STARTUP:  if (t_rem <= CW'(1)) state_nxt = ST_INIT_PRE;
            ST_INIT_PRE: begin issue = 1'b1; gap = CW'(T_RP); after = ST_INIT_REF; end
            ST_INIT_REF: begin
                issue = 1'b1;
                gap   = CW'(T_RFC);
                after = second_ref_q ? ST_INIT_MRS : ST_INIT_REF;
            end
            ST_INIT_MRS: begin issue = 1'b1; gap = CW'(T_MRD); after = ST_IDLE; end
            ST_IDLE: begin
                if (ref_pending)  state_nxt = ST_REF;
                else if (accept)  state_nxt = ST_ACT;
            end
            ST_ACT: begin issue = 1'b1; gap = CW'(T_RCD); after = ST_RW; end
            ST_RW: begin
                issue = 1'b1;
                after = ap_q ? ST_IDLE : ST_PRE;
                if (ap_q) gap = wr_q ? CW'(G_WR_AP)  : CW'(G_RD_AP);
                else      gap = wr_q ? CW'(G_WR_PRE) : CW'(G_RD_PRE);
            end
            ST_PRE: begin
                issue = 1'b1;
                gap   = wr_q ? CW'(G_WR_POST) : CW'(G_RD_POST);
                after = ST_IDLE;
            end
            ST_REF: begin issue = 1'b1; ref_ack = 1'b1; gap = CW'(T_RFC); after = ST_IDLE; end
            ST_WAIT: if (t_rem <= CW'(1)) state_nxt = resume_q;
            default: state_nxt = ST_IDLE;
        endcase
        if (issue) begin
            t_load = 1'b1;
            t_val  = gap - CW'(1);
            if (gap > CW'(1)) begin
                state_nxt  = ST_WAIT;
                resume_nxt = after;
            end else begin
                state_nxt = after;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_STARTUP;
            resume_q     <= ST_IDLE;
            second_ref_q <= 1'b0;
            init_done_q  <= 1'b0;
        end else begin
            state    <= state_nxt;
            resume_q <= resume_nxt;
            if (state == ST_INIT_REF) second_ref_q <= 1'b1;
            if (state == ST_IDLE)     init_done_q  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            wr_q   <= 1'b0;
            ap_q   <= 1'b0;
        end else if (accept) begin
            bank_q <= req_bank;
            row_q  <= req_row;
            col_q  <= req_col;
            wr_q   <= req_write;
            ap_q   <= req_auto_pc;
        end
    end

    // command outputs
    always_comb begin
        cmd     = CMD_NOP;
        sd_ba   = '0;
        sd_addr = '0;
        unique case (state)
            ST_INIT_PRE: begin cmd = CMD_PRE; sd_addr[AP_BIT] = 1'b1; end
            ST_INIT_REF,
            ST_REF:      cmd = CMD_REF;
            ST_INIT_MRS: begin cmd = CMD_MRS; sd_addr = MODE_WORD; end
            ST_ACT: begin
                cmd     = CMD_ACT;
                sd_ba   = bank_q;
                sd_addr = ADDR_W'(row_q);
            end
            ST_RW: begin
                cmd                 = wr_q ? CMD_WR : CMD_RD;
                sd_ba               = bank_q;
                sd_addr[COL_W-1:0]  = col_q;
                sd_addr[AP_BIT]     = ap_q;
            end
            ST_PRE: begin cmd = CMD_PRE; sd_ba = bank_q; end
            default: cmd = CMD_NOP;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    // spacing monitors for the assertions
    logic [SW-1:0] since_act, since_pre;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= SW'(SAT);
            since_pre <= SW'(SAT);
        end else begin
            if (cmd == CMD_ACT)              since_act <= SW'(1);
            else if (since_act != SW'(SAT))  since_act <= since_act + SW'(1);
            if (cmd == CMD_PRE)              since_pre <= SW'(1);
            else if (since_pre != SW'(SAT))  since_pre <= since_pre + SW'(1);
        end
    end

    assert_rcd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> since_act >= SW'(T_RCD));
    assert_ras_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE && init_done_q) |-> since_act >= SW'(T_RAS));
    assert_rp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> since_pre >= SW'(T_RP));
    assert_rc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> since_act >= SW'(T_RC));
    assert_ready_nop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cmd == CMD_NOP);
    assert_refresh_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pending |-> !req_ready);
    assert_act_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> cmd == CMD_ACT);
    assert_init_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_q |=> init_done_q);

endmodule

// File: tb/sdram_sequencer_bench.sv
module sdram_sequencer_bench;

    localparam int T_INIT = 20;
    localparam int REFI   = 300;
    localparam int T_RCD  = 2;
    localparam int T_RP   = 2;
    localparam int T_RAS  = 5;
    localparam int T_RC   = 7;
    localparam int T_WR   = 2;
    localparam int T_RFC  = 7;
    localparam int T_MRD  = 2;
    localparam logic [11:0] MODE = 12'h020;

    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                           C_NOP = 4'b0111;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_auto_pc = 1'b0;
    logic [1:0] req_bank = '0;
    logic [11:0] req_row = '0;
    logic [8:0] req_col = '0;
    logic req_ready, init_done, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0] sd_ba;
    logic [11:0] sd_addr;

    sdram_sequencer #(.T_INIT(T_INIT), .REFI(REFI)) u_sdram_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_auto_pc(req_auto_pc), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_ready(req_ready), .init_done(init_done),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_rw_cmd(input logic wr);
        return wr ? C_WR : C_RD;
    endfunction

    function automatic logic [11:0] exp_rw_addr(input logic [8:0] col, input logic ap);
        return {1'b0, ap, 1'b0, col};
    endfunction

    // expected request queue
    logic [1:0]  q_bank [0:1023];
    logic [11:0] q_row  [0:1023];
    logic [8:0]  q_col  [0:1023];
    logic        q_wr   [0:1023];
    logic        q_ap   [0:1023];
    int q_wi = 0, q_ri = 0;
    int acc_cyc = -100, rel_cyc = 0;
    bit accepted_flag = 1'b0;

    int init_step = 0;
    int last_act = -1000, last_pre = -1000, last_wr = -1000, last_ref = -1000;
    int last_mrs = -1000, ref_mark = -1000;
    logic [1:0] cur_bank = '0; logic [8:0] cur_col = '0;
    logic cur_wr = 1'b0, cur_ap = 1'b1; bit have_cur = 1'b0, pre_seen = 1'b0;
    int n_served = 0, n_nonap = 0, n_pre_op = 0, n_coll = 0, n_ref_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin : mon
            logic [3:0] c;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (req_ready) check(c == C_NOP, "R11", "ready cycle command", int'(c), int'(C_NOP));
            if (req_valid && req_ready) begin
                q_bank[q_wi % 1024] = req_bank; q_row[q_wi % 1024] = req_row;
                q_col[q_wi % 1024] = req_col; q_wr[q_wi % 1024] = req_write;
                q_ap[q_wi % 1024] = req_auto_pc;
                q_wi++; acc_cyc = cyc; accepted_flag = 1'b1;
            end
            case (c)
                C_NOP: ;
                C_PRE: begin
                    if (init_step == 0) begin
                        check(sd_addr[10] == 1'b1, "R3", "init precharge A10", int'(sd_addr[10]), 1);
                        check(cyc - rel_cyc >= T_INIT, "R2", "startup wait", cyc - rel_cyc, T_INIT);
                        init_step = 1;
                    end else begin
                        check(have_cur && !cur_ap, "R5", "precharge only for non-auto access", int'(cur_ap), 0);
                        check(sd_ba == cur_bank, "R6", "precharge bank", int'(sd_ba), int'(cur_bank));
                        check(sd_addr[10] == 1'b0, "R6", "precharge A10", int'(sd_addr[10]), 0);
                        check(cyc - last_act >= T_RAS, "R7", "act to pre", cyc - last_act, T_RAS);
                        if (cur_wr) check(cyc - last_wr >= T_WR, "R7", "write to pre", cyc - last_wr, T_WR);
                        pre_seen = 1'b1; n_pre_op++;
                    end
                    last_pre = cyc;
                end
                C_REF: begin
                    if (init_step == 1) begin
                        check(cyc - last_pre >= T_RP, "R8", "init pre to ref", cyc - last_pre, T_RP);
                        init_step = 2;
                    end else if (init_step == 2) begin
                        check(cyc - last_ref >= T_RFC, "R9", "ref to ref", cyc - last_ref, T_RFC);
                        init_step = 3;
                    end else begin
                        check(init_step == 4, "R3", "refresh order", init_step, 4);
                        check(cyc - ref_mark <= REFI + 20, "R10", "refresh late", cyc - ref_mark, REFI + 20);
                        if (n_ref_run > 0)
                            check(cyc - ref_mark >= REFI - 20, "R10", "refresh early", cyc - ref_mark, REFI - 20);
                        check(!req_ready, "R10", "ready during refresh", int'(req_ready), 0);
                        check(cyc - last_act >= T_RC, "R8", "act to refresh", cyc - last_act, T_RC);
                        if (req_valid) n_coll++;
                        n_ref_run++; ref_mark = cyc;
                    end
                    last_ref = cyc;
                end
                C_MRS: begin
                    check(init_step == 3, "R3", "mode load order", init_step, 3);
                    check(sd_addr == MODE, "R3", "mode word", int'(sd_addr), int'(MODE));
                    check(!init_done, "R3", "init_done during mode load", int'(init_done), 0);
                    check(cyc - last_ref >= T_RFC, "R9", "ref to mode", cyc - last_ref, T_RFC);
                    init_step = 4; last_mrs = cyc; ref_mark = cyc;
                end
                C_ACT: begin
                    check(init_step == 4, "R3", "activate before init", init_step, 4);
                    check(init_done, "R3", "init_done at activate", int'(init_done), 1);
                    check(cyc - last_mrs >= T_MRD, "R9", "mode to act", cyc - last_mrs, T_MRD);
                    check(cyc - last_ref >= T_RFC, "R9", "ref to act", cyc - last_ref, T_RFC);
                    check(cyc - last_act >= T_RC, "R8", "act to act", cyc - last_act, T_RC);
                    check(cyc - last_pre >= T_RP, "R8", "pre to act", cyc - last_pre, T_RP);
                    if (have_cur && !cur_ap)
                        check(pre_seen, "R6", "missing precharge", int'(pre_seen), 1);
                    check(cyc == acc_cyc + 1, "R12", "accept to act", cyc - acc_cyc, 1);
                    if (q_ri < q_wi) begin
                        check(sd_ba == q_bank[q_ri % 1024], "R4", "act bank", int'(sd_ba), int'(q_bank[q_ri % 1024]));
                        check(sd_addr == q_row[q_ri % 1024], "R4", "act row", int'(sd_addr), int'(q_row[q_ri % 1024]));
                        cur_bank = q_bank[q_ri % 1024]; cur_col = q_col[q_ri % 1024];
                        cur_wr = q_wr[q_ri % 1024]; cur_ap = q_ap[q_ri % 1024];
                        q_ri++;
                    end else begin
                        check(1'b0, "R12", "activate without request", q_ri, q_wi);
                    end
                    if (!cur_ap) n_nonap++;
                    have_cur = 1'b1; pre_seen = 1'b0; n_served++; last_act = cyc;
                end
                C_RD, C_WR: begin
                    check(c == exp_rw_cmd(cur_wr), "R4", "read/write kind", int'(c), int'(exp_rw_cmd(cur_wr)));
                    check(sd_ba == cur_bank, "R4", "rw bank", int'(sd_ba), int'(cur_bank));
                    check(sd_addr == exp_rw_addr(cur_col, cur_ap), "R5", "rw address",
                          int'(sd_addr), int'(exp_rw_addr(cur_col, cur_ap)));
                    check(cyc - last_act >= T_RCD, "R7", "act to rw", cyc - last_act, T_RCD);
                    if (c == C_WR) last_wr = cyc;
                end
                default: check(1'b0, "R1", "illegal command", int'(c), int'(C_NOP));
            endcase
        end
    end

    task automatic send(input logic [1:0] b, input logic [11:0] r, input logic [8:0] c,
                        input logic w, input logic a);
        @(posedge clk); #1;
        accepted_flag = 1'b0;
        req_valid = 1'b1; req_bank = b; req_row = r; req_col = c;
        req_write = w; req_auto_pc = a;
        do begin @(posedge clk); #1; end while (!accepted_flag);
        accepted_flag = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        void'($urandom(32'd20241));
        repeat (3) begin
            @(negedge clk);
            check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R2", "reset command",
                  int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(C_NOP));
            check(!req_ready && !init_done, "R2", "reset ready/init_done",
                  int'({req_ready, init_done}), 0);
        end
        @(posedge clk); #1; rst_n = 1'b1; rel_cyc = cyc;
        wait (init_done == 1'b1);
        // random mixed traffic
        for (int i = 0; i < 200; i++) begin
            send(2'($urandom), 12'($urandom), 9'($urandom), 1'($urandom), 1'($urandom));
            idle(int'($urandom % 4));
        end
        // continuous requests to collide with refresh (R10)
        for (int i = 0; i < 120; i++)
            send(2'($urandom), 12'($urandom), 9'($urandom), 1'($urandom), 1'($urandom));
        // directed extremes
        send(2'd3, 12'hFFF, 9'h1FF, 1'b1, 1'b1);
        send(2'd0, 12'h000, 9'h000, 1'b0, 1'b0);
        send(2'd2, 12'hA5A, 9'h155, 1'b1, 1'b0);
        send(2'd1, 12'h5A5, 9'h0AA, 1'b0, 1'b1);
        idle(40);
        check(n_served == q_wi, "R12", "served vs accepted", n_served, q_wi);
        check(n_pre_op == n_nonap, "R6", "precharges vs non-auto accesses", n_pre_op, n_nonap);
        check(n_coll >= 1, "R10", "refresh/request collisions", n_coll, 1);
        check(n_ref_run >= 2, "R10", "refreshes issued", n_ref_run, 2);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
            summary();
            $finish;
        end
    end

endmodule